// File: doc/BRIEF.md
# Frame-Aligned Acquisition Gate with Decimation

This block sits between a bank of free-running converters and the sample FIFO. The converters never stop; they present one channel sample per valid beat, with a marker on the beat that carries the first channel of each sample instant. The gate decides, a whole frame at a time, which samples are written. A frame is the set of channels for one sample instant, starting at the first channel and running consecutively up to a programmed count. Samples past that count are dropped.

Acquisition is requested either by a software run bit or by an external level input. A select bit picks the source. The request level is looked at only on a frame-start beat, so writing always begins at a frame start and always ends after the last counted channel of a frame. A decimation setting keeps one frame out of every N, for N from 1 to 16. The decimation counter advances on every frame start, whether acquisition is running or not, so the kept frames stay on a fixed grid that several boards can share.

Top module: `acq_frame_gate`

## Requirements
- R1: After reset `fifo_wr` and `acq_active` are 0. Sample beats that arrive before the first frame-start beat after reset are never written.
- R2: An accepted sample beat produces `fifo_wr`=1 in the next cycle, with `fifo_data` equal to that beat's `smp_data`. Idle cycles (`smp_valid`=0) produce no write.
- R3: A frame begins on the beat with `smp_first`=1 (channel 0). Within a kept frame, only the first C beats are written, where C is the effective channel count. Later beats of the frame are discarded.
- R4: `chan_cnt_m1` holds the channel count minus one. An odd count is reduced to the next lower even count, so C = 2*floor((chan_cnt_m1+1)/2). A value of 0 gives C=0, and nothing is written.
- R5: With `src_ext`=0, `sw_run` is the request. Its level on a frame-start beat decides the whole frame. Changes in the middle of a frame take effect only at the next frame start.
- R6: With `src_ext`=1, `ext_run` is the request, under the same frame rule. The unselected run input has no effect.
- R7: `decim_m1` holds N-1. Numbering frame starts from 0 after reset, a frame is kept only if its index mod N is 0. Frame starts that are not written still advance this count.
- R8: `acq_active` equals the request level seen on the most recent frame-start beat. It is updated one cycle after that beat and is held otherwise.
- R9: A request that drops and later returns high restarts writing at the next frame start that is also a kept decimation slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A channel sample is present this cycle |
| smp_first | input | 1 | This sample is channel 0 of a new frame |
| smp_data | input | DW | Sample value |
| sw_run | input | 1 | Software run request level |
| ext_run | input | 1 | External run request level |
| src_ext | input | 1 | 1 selects `ext_run`, 0 selects `sw_run` |
| chan_cnt_m1 | input | CW | Channel count minus one |
| decim_m1 | input | DECW | Decimation factor minus one |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | DW | FIFO write data |
| acq_active | output | 1 | Request level latched at the last frame start |

## Verification
The bench sweeps every decimation factor against every channel-count value on an eight-channel configuration. In each run the request level changes in the middle of a frame, and a fresh reference model supplies the expected result.

- A gate that acted on the request level at once would cut frames short or start them late, and mid-frame beats would then miss or gain writes.
- A wrong odd-count rounding would write one channel too many on half of the count settings.
- A decimation counter that paused while stopped would shift the kept-frame grid after the first stop.
- Beats before the first frame marker after reset, and a count of zero, check that nothing leaks through when no frame is open.

// File: rtl/acq_frame_gate.sv
module acq_frame_gate #(
  parameter int DW     = 24,
  parameter int MAX_CH = 32,
  parameter int CW     = $clog2(MAX_CH),
  parameter int DECW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_valid,
  input  logic            smp_first,
  input  logic [DW-1:0]   smp_data,
  input  logic            sw_run,
  input  logic            ext_run,
  input  logic            src_ext,
  input  logic [CW-1:0]   chan_cnt_m1,
  input  logic [DECW-1:0] decim_m1,
  output logic            fifo_wr,
  output logic [DW-1:0]   fifo_data,
  output logic            acq_active
);
  localparam int IW = CW + 1;

  logic [IW-1:0]   ch_q, ch_now, eff_cnt;
  logic [DECW-1:0] dcnt_q;
  logic            frame_q, keep_now, run_req, sof;

  assign run_req  = src_ext ? ext_run : sw_run;
  assign sof      = smp_valid & smp_first;
  assign eff_cnt  = ({1'b0, chan_cnt_m1} + IW'(1)) & ~IW'(1);
  assign ch_now   = smp_first ? '0 : ((ch_q == '1) ? ch_q : ch_q + IW'(1));
  assign keep_now = smp_first ? (run_req && dcnt_q == '0) : frame_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_q       <= '1;
      frame_q    <= 1'b0;
      dcnt_q     <= '0;
      acq_active <= 1'b0;
      fifo_wr    <= 1'b0;
      fifo_data  <= '0;
    end else begin
      fifo_wr <= smp_valid && keep_now && (ch_now < eff_cnt);
      if (smp_valid) begin
        ch_q      <= ch_now;
        frame_q   <= keep_now;
        fifo_data <= smp_data;
      end
      if (sof) begin
        dcnt_q     <= (dcnt_q >= decim_m1) ? '0 : dcnt_q + DECW'(1);
        acq_active <= run_req;
      end
    end
  end
endmodule

// File: rtl/acq_gate_checker.sv
module acq_gate_checker #(
  parameter int DW   = 24,
  parameter int CW   = 5,
  parameter int DECW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            smp_valid,
  input logic            smp_first,
  input logic [DW-1:0]   smp_data,
  input logic            sw_run,
  input logic            ext_run,
  input logic            src_ext,
  input logic [CW-1:0]   chan_cnt_m1,
  input logic [DECW-1:0] decim_m1,
  input logic            fifo_wr,
  input logic [DW-1:0]   fifo_data,
  input logic            acq_active
);
  logic req_seen, start_beat;
  assign req_seen   = src_ext ? ext_run : sw_run;
  assign start_beat = smp_valid && smp_first;

  assert_wr_after_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> $past(smp_valid));

  assert_data_matches_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> fifo_data == $past(smp_data));

  assert_wr_needs_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> acq_active);

  assert_active_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !start_beat |=> $stable(acq_active));

  assert_low_request_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_beat && !req_seen) |=> !fifo_wr);

  assert_zero_count_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_cnt_m1 == '0) |=> !fifo_wr);
endmodule

bind acq_frame_gate acq_gate_checker #(.DW(DW), .CW(CW), .DECW(DECW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_first(smp_first),
  .smp_data(smp_data), .sw_run(sw_run), .ext_run(ext_run), .src_ext(src_ext),
  .chan_cnt_m1(chan_cnt_m1), .decim_m1(decim_m1), .fifo_wr(fifo_wr),
  .fifo_data(fifo_data), .acq_active(acq_active)
);

// File: tb/test_acq_frame_gate.sv
module test_acq_frame_gate;
  localparam int DW = 24, MAX_CH = 8, CW = 3, DECW = 4, NF = 18;

  logic clk = 0, rst_n = 0;
  logic smp_valid = 0, smp_first = 0, sw_run = 0, ext_run = 0, src_ext = 0;
  logic [DW-1:0] smp_data = '0;
  logic [CW-1:0] chan_cnt_m1 = '0;
  logic [DECW-1:0] decim_m1 = '0;
  logic fifo_wr, acq_active;
  logic [DW-1:0] fifo_data;

  acq_frame_gate #(.DW(DW), .MAX_CH(MAX_CH), .CW(CW), .DECW(DECW)) i_acq_frame_gate (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_first(smp_first),
    .smp_data(smp_data), .sw_run(sw_run), .ext_run(ext_run), .src_ext(src_ext),
    .chan_cnt_m1(chan_cnt_m1), .decim_m1(decim_m1), .fifo_wr(fifo_wr),
    .fifo_data(fifo_data), .acq_active(acq_active));

  always #2.5 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  int f_idx, cur_ch, dfac, cnt_eff, prev_run;
  bit cur_keep, exp_act;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic set_run(bit lvl);
    if (src_ext) begin ext_run = lvl; sw_run = ~lvl; end
    else begin sw_run = lvl; ext_run = ~lvl; end
  endtask

  task automatic beat(bit first, logic [DW-1:0] d, bit lvl);
    bit exp_wr;
    string tag;
    smp_valid = 1; smp_first = first; smp_data = d; set_run(lvl);
    if (first) begin
      f_idx++;
      cur_ch = 0;
      cur_keep = lvl && (f_idx % dfac == 0);
      exp_act = lvl;
    end else if (f_idx >= 0) cur_ch++;
    exp_wr = (f_idx >= 0) && cur_keep && (cur_ch < cnt_eff);
    if (f_idx < 0) tag = "R1";
    else if (!lvl && first) tag = src_ext ? "R6" : "R5";
    else if (first && lvl && prev_run == 0 && (f_idx % dfac == 0)) tag = "R9";
    else if (first && lvl) tag = "R7";
    else if (cur_keep && cur_ch >= cnt_eff) tag = (chan_cnt_m1[0] == 1'b0) ? "R4" : "R3";
    else tag = src_ext ? "R6" : "R5";
    if (first) prev_run = lvl;
    @(posedge clk); @(negedge clk);
    check(fifo_wr == exp_wr, tag, "fifo_wr", fifo_wr, exp_wr);
    if (exp_wr) check(fifo_data == d, "R2", "fifo_data", fifo_data, d);
    check(acq_active == exp_act, "R8", "acq_active", acq_active, exp_act);
  endtask

  task automatic idle();
    smp_valid = 0; smp_first = 0;
    @(posedge clk); @(negedge clk);
    check(fifo_wr == 0, "R2", "idle fifo_wr", fifo_wr, 0);
  endtask

  function automatic bit run_of(int k, int d, int m);
    return ((k * 3 + d + m) % 4) != 0 || k == d;
  endfunction

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    for (int d = 1; d <= 16; d++) begin
      for (int m = 0; m < MAX_CH; m++) begin
        rst_n = 0; smp_valid = 0; smp_first = 0;
        decim_m1 = DECW'(d - 1); chan_cnt_m1 = CW'(m);
        src_ext = ((d + m) % 2) == 1;
        dfac = d; cnt_eff = ((m + 1) / 2) * 2;
        f_idx = -1; cur_ch = 0; cur_keep = 0; exp_act = 0; prev_run = -1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rst_n = 1;
        @(posedge clk); @(negedge clk);
        check(fifo_wr == 0 && acq_active == 0, "R1", "reset outputs",
              {fifo_wr, acq_active}, 0);
        for (int i = 0; i < 3; i++) beat(0, DW'(24'hA00 + i), 1'b1);
        for (int k = 0; k < NF; k++) begin
          for (int c = 0; c < MAX_CH; c++)
            beat(c == 0, DW'((d << 16) | (k << 8) | (m << 4) | c),
                 (c < 4) ? run_of(k, d, m) : run_of(k + 1, d, m));
          if (k % 5 == 4) idle();
        end
      end
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule